// File: doc/BRIEF.md
# In-Place RAM Bubble Sorter

This block sorts an array of unsigned 16-bit words that sits in a single-port synchronous RAM. It rewrites the array in the same locations. A controller loads the RAM, then pulses `kick`. From that point the sorter drives the RAM's address, write data and write enable, and it reads the RAM's output one clock after each address. When the array is in order, it pulses `done_pulse` for one cycle and releases the port.

The sorter runs passes of adjacent compare-and-exchange steps over elements `i` and `i+1`. Each pass ends one element earlier than the pass before it, because the far end of the array is already settled. A pair that is out of order is written back as two writes on consecutive cycles. The sort stops after the first pass that makes no exchange, or after N-1 passes, whichever comes first. The level of `order_desc` when the sort is kicked sets the direction: 0 gives increasing order and 1 gives decreasing order.

Top module: `ram_bubble_sorter`

## Requirements
- R1: After synchronous reset, `ram_we` and `done_pulse` are both 0 until a sort is kicked.
- R2: With `order_desc` = 0 at the kick, the RAM holds the original multiset in non-decreasing order when `done_pulse` is asserted. This includes arrays that hold 16'h0000 and 16'hFFFF.
- R3: With `order_desc` = 1 at the kick, the RAM holds the original multiset in non-increasing order when `done_pulse` is asserted.
- R4: `order_desc` is sampled only in the cycle the kick is accepted. Changing it during a sort does not change the resulting order.
- R5: Equal elements are never exchanged. An array whose elements are all equal completes without a single RAM write.
- R6: The sort ends after a pass with no exchange, or after N-1 passes. An array already in the requested order completes with no writes, and `done_pulse` appears no later than 3*(N-1)+1 cycles after the kick edge.
- R7: The read data for an address is used one cycle after that address is presented. An exchange writes address i and then address i+1 on two consecutive cycles, and never three writes in a row.
- R8: `done_pulse` is high for exactly one cycle per sort.
- R9: A `kick` that arrives while a sort is running is ignored. The running sort still completes correctly and produces exactly one `done_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start request, accepted only when idle |
| order_desc | input | 1 | 0 selects increasing order, 1 selects decreasing order |
| ram_addr | output | $clog2(N) | RAM address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 16 | RAM read data, valid one cycle after the address |
| done_pulse | output | 1 | One-cycle pulse when the array is ordered |

## Verification
The sorter is run on several arrays, each of which exposes a different fault:
- A scrambled array that holds both value extremes, sorted both ways. This separates the two comparison directions and catches a read-latency slip.
- An array with repeated values, which catches a comparison that is not strict.
- An array of identical values and an already-ordered array. Both must finish with zero writes, which exposes a missing early exit or a spurious exchange.
- A fully reversed array, which drives the sorter through the maximum number of passes.

Two further runs disturb a sort in progress, one by flipping `order_desc` and one by re-kicking. They show whether the direction is latched and whether busy-time kicks are ignored.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ORD_UP   = 1'b0,
        ORD_DOWN = 1'b1
    } order_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CMP,
        ST_WR_A,
        ST_WR_B,
        ST_DONE
    } state_e;

    // lo holds element i, hi holds element i+1
    typedef struct packed {
        word_t lo;
        word_t hi;
    } pair_t;

    // strict comparison: equal words are never reported out of order
    function automatic logic out_of_order(word_t first, word_t second, order_e ord);
        return (ord == ORD_UP) ? (first > second) : (first < second);
    endfunction

endpackage

// File: rtl/sort_pair_cmp.sv
module sort_pair_cmp
    import sorter_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_a,
    input  logic   cap_b,
    input  word_t  rdata,
    input  order_e order,
    output pair_t  pair,
    output logic   swap_req
);

    pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            if (cap_a) pair_q.lo <= rdata;
            if (cap_b) pair_q.hi <= rdata;
        end
    end

    // the second element is compared straight off the RAM output
    assign swap_req = out_of_order(pair_q.lo, rdata, order);
    assign pair     = pair_q;

    AST_EQUAL_KEPT: assert property (@(posedge clk) disable iff (rst)
        swap_req |-> (pair_q.lo != rdata)); // R5

endmodule

// File: rtl/sort_counters.sv
module sort_counters #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic          note_swap,
    output logic [IW-1:0] idx,
    output logic          at_pass_end,
    output logic          last_pass,
    output logic          swapped
);

    localparam logic [IW-1:0] LAST = IW'(N - 2);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] pass_q;
    logic          swp_q;
    logic [IW-1:0] limit;

    assign limit       = LAST - pass_q;
    assign at_pass_end = (idx_q == limit);
    assign last_pass   = (pass_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            pass_q <= '0;
            swp_q  <= 1'b0;
        end else if (clr) begin
            idx_q  <= '0;
            pass_q <= '0;
            swp_q  <= 1'b0;
        end else begin
            if (step) begin
                if (at_pass_end) begin
                    idx_q <= '0;
                    swp_q <= 1'b0;
                    if (!last_pass) pass_q <= pass_q + 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (note_swap) swp_q <= 1'b1;
        end
    end

    assign idx     = idx_q;
    assign swapped = swp_q;

    AST_IDX_WITHIN: assert property (@(posedge clk) disable iff (rst)
        idx_q <= limit); // R6
    AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pass_q <= LAST); // R6

endmodule

// File: rtl/sort_fsm.sv
module sort_fsm
    import sorter_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   kick,
    input  logic   order_sel,
    input  logic   swap_req,
    input  logic   at_pass_end,
    input  logic   last_pass,
    input  logic   swapped,
    output state_e state,
    output order_e order,
    output logic   clr,
    output logic   cap_a,
    output logic   cap_b,
    output logic   step,
    output logic   note_swap,
    output logic   done
);

    state_e state_q, state_d;
    order_e order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            order_q <= ORD_UP;
        end else begin
            state_q <= state_d;
            if (clr) order_q <= order_e'(order_sel);
        end
    end

    always_comb begin
        state_d   = state_q;
        clr       = 1'b0;
        cap_a     = 1'b0;
        cap_b     = 1'b0;
        step      = 1'b0;
        note_swap = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (kick) begin
                    clr     = 1'b1;
                    state_d = ST_RD_A;
                end
            end
            ST_RD_A: state_d = ST_RD_B;
            ST_RD_B: begin
                cap_a   = 1'b1;
                state_d = ST_CMP;
            end
            ST_CMP: begin
                cap_b = 1'b1;
                if (swap_req) begin
                    note_swap = 1'b1;
                    state_d   = ST_WR_A;
                end else begin
                    step = 1'b1;
                    if (at_pass_end && (!swapped || last_pass))
                        state_d = ST_DONE;
                    else
                        state_d = ST_RD_A;
                end
            end
            ST_WR_A: state_d = ST_WR_B;
            ST_WR_B: begin
                step    = 1'b1;
                state_d = (at_pass_end && last_pass) ? ST_DONE : ST_RD_A;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
    assign order = order_q;

    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(order_q)); // R4

endmodule

// File: rtl/ram_bubble_sorter.sv
module ram_bubble_sorter
    import sorter_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic          order_desc,
    output logic [IW-1:0] ram_addr,
    output logic [15:0]   ram_wdata,
    output logic          ram_we,
    input  logic [15:0]   ram_rdata,
    output logic          done_pulse
);

    state_e        state;
    order_e        order;
    pair_t         pair;
    logic          clr, cap_a, cap_b, step, note_swap, done;
    logic          swap_req, at_pass_end, last_pass, swapped;
    logic [IW-1:0] idx;

    sort_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .kick        (kick),
        .order_sel   (order_desc),
        .swap_req    (swap_req),
        .at_pass_end (at_pass_end),
        .last_pass   (last_pass),
        .swapped     (swapped),
        .state       (state),
        .order       (order),
        .clr         (clr),
        .cap_a       (cap_a),
        .cap_b       (cap_b),
        .step        (step),
        .note_swap   (note_swap),
        .done        (done)
    );

    sort_counters #(.N(N), .IW(IW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .step        (step),
        .note_swap   (note_swap),
        .idx         (idx),
        .at_pass_end (at_pass_end),
        .last_pass   (last_pass),
        .swapped     (swapped)
    );

    sort_pair_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .rdata    (ram_rdata),
        .order    (order),
        .pair     (pair),
        .swap_req (swap_req)
    );

    // the second element of a pair sits one address above the first
    always_comb begin
        ram_addr  = idx;
        ram_wdata = pair.hi;
        ram_we    = 1'b0;
        unique case (state)
            ST_RD_B: ram_addr = idx + 1'b1;
            ST_WR_A: ram_we   = 1'b1;
            ST_WR_B: begin
                ram_addr  = idx + 1'b1;
                ram_wdata = pair.lo;
                ram_we    = 1'b1;
            end
            default: ;
        endcase
    end

    assign done_pulse = done;

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1)); // R7
    AST_WRITE_BURST: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_we, 2) && $past(ram_we)) |-> !ram_we); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> !ram_we); // R8

endmodule

// File: tb/sim_ram_bubble_sorter.sv
`timescale 1ns/1ps
module sim_ram_bubble_sorter;

    localparam int N  = 16;
    localparam int IW = $clog2(N);
    localparam int RUN_LIMIT = 4000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          kick = 1'b0;
    logic          order_desc = 1'b0;
    logic [IW-1:0] ram_addr;
    logic [15:0]   ram_wdata;
    logic          ram_we;
    logic [15:0]   ram_rdata;
    logic          done_pulse;

    always #4 clk = ~clk;

    ram_bubble_sorter #(.N(N)) u0 (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .order_desc (order_desc),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_rdata  (ram_rdata),
        .done_pulse (done_pulse)
    );

    // single-port RAM, one cycle read latency
    logic [15:0] ram [N];
    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        ram_rdata <= ram[ram_addr];
    end

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int pair_err = 0;
    string cur_tag = "R2";
    logic [15:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: pops expected words when the design reports completion
    logic          prev_we = 1'b0;
    logic [IW-1:0] prev_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we && prev_we && ram_addr != prev_addr + 1'b1) pair_err++;
            prev_we   = ram_we;
            prev_addr = ram_addr;
            if (ram_we) wr_cnt++;
            if (done_pulse) begin
                done_cnt++;
                for (int i = 0; i < N; i++) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_tag, int'(ram[i]), 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        check(ram[i] == e, cur_tag, int'(ram[i]), int'(e));
                    end
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // driver: preload, push expected order, kick, wait for completion
    task automatic run_sort(input logic [15:0] d [N], input bit desc, input string tag,
                            input int flip_at, input int kick_at,
                            output int cycles, output int writes, output int dones);
        logic [15:0] s [N];
        int w0, d0, p0;
        for (int i = 0; i < N; i++) s[i] = d[i];
        for (int p = 0; p < N - 1; p++)
            for (int j = 0; j < N - 1 - p; j++)
                if (desc ? (s[j] < s[j+1]) : (s[j] > s[j+1])) begin
                    logic [15:0] t;
                    t = s[j]; s[j] = s[j+1]; s[j+1] = t;
                end
        @(negedge clk);
        for (int i = 0; i < N; i++) ram[i] = d[i];
        for (int i = 0; i < N; i++) exp_q.push_back(s[i]);
        cur_tag = tag;
        w0 = wr_cnt; d0 = done_cnt; p0 = pair_err;
        order_desc = desc;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        cycles = 1;
        while (!done_pulse && cycles < RUN_LIMIT) begin
            @(negedge clk);
            cycles++;
            if (cycles == flip_at) order_desc = ~order_desc;
            kick = (cycles == kick_at);
        end
        kick = 1'b0;
        repeat (4) @(negedge clk);
        writes = wr_cnt - w0;
        dones  = done_cnt - d0;
        check(cycles < RUN_LIMIT, {tag, " completion"}, cycles, RUN_LIMIT);
        check(dones == 1, "R8 one done pulse", dones, 1);
        check(pair_err == p0, "R7 adjacent write pair", pair_err - p0, 0);
        exp_q.delete();
    endtask

    initial begin
        logic [15:0] d [N];
        int cyc_n, wr_n, dn_n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ram_we == 1'b0, "R1 we after reset", int'(ram_we), 0);
        check(done_pulse == 1'b0, "R1 done after reset", int'(done_pulse), 0);
        repeat (3) @(negedge clk);
        check(wr_cnt == 0 && done_cnt == 0, "R1 idle quiet", wr_cnt + done_cnt, 0);

        // scrambled with both extremes
        for (int i = 0; i < N; i++) d[i] = 16'((i * 40503 + 12345) ^ (i << 7));
        d[3] = 16'hFFFF; d[9] = 16'h0000;
        run_sort(d, 1'b0, "R2", 0, 0, cyc_n, wr_n, dn_n);
        run_sort(d, 1'b1, "R3", 0, 0, cyc_n, wr_n, dn_n);

        // repeated values both ways
        for (int i = 0; i < N; i++) d[i] = 16'(((i * 7) % 5) * 16'h1111);
        run_sort(d, 1'b0, "R2", 0, 0, cyc_n, wr_n, dn_n);
        run_sort(d, 1'b1, "R3", 0, 0, cyc_n, wr_n, dn_n);

        // all equal: no writes at all
        for (int i = 0; i < N; i++) d[i] = 16'hA5A5;
        run_sort(d, 1'b0, "R5", 0, 0, cyc_n, wr_n, dn_n);
        check(wr_n == 0, "R5 equal array writes", wr_n, 0);

        // already ordered: one pass, no writes
        for (int i = 0; i < N; i++) d[i] = 16'(i * 3);
        run_sort(d, 1'b0, "R6", 0, 0, cyc_n, wr_n, dn_n);
        check(wr_n == 0, "R6 sorted array writes", wr_n, 0);
        check(cyc_n <= 3 * (N - 1) + 1, "R6 early exit cycles", cyc_n, 3 * (N - 1) + 1);

        // fully reversed: maximum passes
        for (int i = 0; i < N; i++) d[i] = 16'(16'hFFF0 - i);
        run_sort(d, 1'b0, "R6", 0, 0, cyc_n, wr_n, dn_n);
        check(wr_n == N * (N - 1), "R6 reversed write count", wr_n, N * (N - 1));

        // direction flipped during the sort
        for (int i = 0; i < N; i++) d[i] = 16'((i * 9001) ^ 16'h5A5A);
        run_sort(d, 1'b0, "R4", 5, 0, cyc_n, wr_n, dn_n);
        order_desc = 1'b0;

        // re-kick during the sort
        run_sort(d, 1'b1, "R9", 0, 20, cyc_n, wr_n, dn_n);
        check(dn_n == 1, "R9 single completion", dn_n, 1);

        finish_run();
    end

endmodule